// File: doc/BRIEF.md
# Panel Register Write Sequencer

This block sets up a TFT panel through a write-only serial register port. A host gives it a one-cycle start strobe with a two-bit operation code. It then plays out a short, fixed list of register writes on an SPI link (clock, data out, active-low chip select). It raises busy for the whole run and pulses done when the run ends.

Each register write is two chip-select frames of 24 bits. The first frame carries a selector byte that marks it as an index frame, a zero byte and the register number. The second frame carries a selector byte that marks it as a data frame and the 16-bit value, high byte first. Three operations exist: power up, shut down and resume. Power up and resume differ only in the order of their two writes. The display-orientation word written to the output-control register is built from a 16-bit mode input. Four of its bits are taken from the mode input and the rest are fixed.

Top module: `panel_cfg_seq`

## Requirements
- R1: An index frame is 24 bits sent MSB first under one low period of chip select: 0x74, 0x00, then the register number.
- R2: A data frame is 24 bits sent MSB first under one low period of chip select: 0x76, then the value's high byte, then its low byte.
- R3: Operation code 2'b00 (power up) writes register 0x11 with 0x0000, then register 0x01 with the orientation word. That is four frames in total.
- R4: Operation code 2'b10 (resume) writes register 0x01 with the orientation word, then register 0x11 with 0x0000.
- R5: Operation code 2'b01 (shut down) makes exactly one write: register 0x11 with 0x0001.
- R6: The orientation word is (mode & 0x2B00) | 0x00EF, where mode bits 8, 9, 11 and 13 are the only ones used. The mode is sampled in the cycle the start is accepted, and later changes have no effect on the run.
- R7: The link uses SPI mode 0. The clock idles low while chip select is high, data changes only while the clock is low, and one clock period is CLK_DIV system cycles.
- R8: Between two frames of one run, chip select stays high for at least CLK_DIV system cycles.
- R9: Busy is high from the cycle after an accepted start until the run ends. Done is a single-cycle pulse in the first cycle with busy low again. Chip select is low only while busy is high.
- R10: A start while busy is ignored, and so is a start with operation code 2'b11. Neither adds frames nor changes the running operation.
- R11: After reset, busy and done are low, chip select is high and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start strobe for one operation |
| cmd_op | input | 2 | Operation: 00 power up, 01 shut down, 10 resume, 11 reserved |
| mode_cfg | input | 16 | Orientation mode bits (8, 9, 11, 13 used) |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out, MSB first |
| spi_cs_n | output | 1 | Active-low chip select, one low period per frame |

## Verification
The bench swaps the mode input to its complement right after the start is accepted. A design that sampled the mode late would send a different orientation word. It also sends all-ones and all-non-mask mode patterns, which catch a wrong mask or default. The bench pokes a second start while a run is in progress and issues the reserved operation code. A design that re-armed would then show extra frames or a changed write order. Frames are decoded from the pins with their bit counts, clock periods and chip-select gaps. A shifter with an off-by-one bit count, a swapped write order between power up and resume, or frames run back to back would each show up as a frame or timing mismatch.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef enum logic [1:0] {
        OP_POWER_ON = 2'b00,
        OP_SHUTDOWN = 2'b01,
        OP_RESUME   = 2'b10,
        OP_RESERVED = 2'b11
    } pcfg_op_e;

    localparam int BYTE_W      = 8;
    localparam int VALUE_W     = 16;
    localparam int FRAME_BYTES = 3;
    localparam int FRAME_W     = FRAME_BYTES * BYTE_W;

    localparam logic [BYTE_W-1:0]  SEL_INDEX  = 8'h74;
    localparam logic [BYTE_W-1:0]  SEL_DATA   = 8'h76;
    localparam logic [BYTE_W-1:0]  REG_POWER  = 8'h11;
    localparam logic [BYTE_W-1:0]  REG_ORIENT = 8'h01;
    localparam logic [VALUE_W-1:0] ORIENT_KEEP = 16'h2B00;
    localparam logic [VALUE_W-1:0] ORIENT_BASE = 16'h2AEF;
    localparam logic [VALUE_W-1:0] PWR_ON_VAL  = 16'h0000;
    localparam logic [VALUE_W-1:0] PWR_OFF_VAL = 16'h0001;

    typedef struct packed {
        logic [BYTE_W-1:0]  regnum;
        logic [VALUE_W-1:0] value;
    } reg_write_t;

    function automatic logic [VALUE_W-1:0] orient_word(input logic [VALUE_W-1:0] mode);
        return (mode & ORIENT_KEEP) | (ORIENT_BASE & ~ORIENT_KEEP);
    endfunction

    function automatic logic last_step(input pcfg_op_e op);
        return (op == OP_SHUTDOWN) ? 1'b0 : 1'b1;
    endfunction

    function automatic reg_write_t step_write(input pcfg_op_e op, input logic step,
                                              input logic [VALUE_W-1:0] word);
        reg_write_t w;
        w.regnum = REG_POWER;
        w.value  = PWR_OFF_VAL;
        case (op)
            OP_POWER_ON: begin
                w.regnum = step ? REG_ORIENT : REG_POWER;
                w.value  = step ? word : PWR_ON_VAL;
            end
            OP_RESUME: begin
                w.regnum = step ? REG_POWER : REG_ORIENT;
                w.value  = step ? PWR_ON_VAL : word;
            end
            default: begin
                w.regnum = REG_POWER;
                w.value  = PWR_OFF_VAL;
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pcfg_tick_gen.sv
module pcfg_tick_gen #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_state_t;

    tick_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (!en) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == LAST) begin
            s_d.cnt = '0;
            tick    = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pcfg_frame_tx.sv
module pcfg_frame_tx #(
    parameter int FRAME_W   = 24,
    parameter int GAP_TICKS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic               active,
    output logic               frame_done,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n
);
    localparam int BW = $clog2(FRAME_W);
    localparam int GW = $clog2(GAP_TICKS + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);
    localparam logic [GW-1:0] LAST_GAP = GW'(GAP_TICKS - 1);

    typedef enum logic [1:0] {TX_IDLE, TX_RUN, TX_GAP} tx_st_e;

    typedef struct packed {
        tx_st_e             st;
        logic [FRAME_W-1:0] shreg;
        logic [BW-1:0]      bitcnt;
        logic [GW-1:0]      gapcnt;
        logic               sclk;
        logic               cs_n;
    } tx_state_t;

    localparam tx_state_t TX_RST = '{st: TX_IDLE, shreg: '0, bitcnt: '0,
                                     gapcnt: '0, sclk: 1'b0, cs_n: 1'b1};

    tx_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        frame_done = 1'b0;
        case (s_q.st)
            TX_IDLE: begin
                if (load) begin
                    s_d.st     = TX_RUN;
                    s_d.shreg  = frame;
                    s_d.bitcnt = '0;
                    s_d.cs_n   = 1'b0;
                    s_d.sclk   = 1'b0;
                end
            end
            TX_RUN: begin
                if (tick) begin
                    if (!s_q.sclk) begin
                        s_d.sclk = 1'b1;
                    end else begin
                        s_d.sclk = 1'b0;
                        if (s_q.bitcnt == LAST_BIT) begin
                            s_d.st     = TX_GAP;
                            s_d.cs_n   = 1'b1;
                            s_d.gapcnt = '0;
                        end else begin
                            s_d.shreg  = {s_q.shreg[FRAME_W-2:0], 1'b0};
                            s_d.bitcnt = s_q.bitcnt + 1'b1;
                        end
                    end
                end
            end
            TX_GAP: begin
                if (tick) begin
                    if (s_q.gapcnt == LAST_GAP) begin
                        s_d.st     = TX_IDLE;
                        frame_done = 1'b1;
                    end else begin
                        s_d.gapcnt = s_q.gapcnt + 1'b1;
                    end
                end
            end
            default: s_d = TX_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= TX_RST;
        else        s_q <= s_d;
    end

    assign active = (s_q.st != TX_IDLE);
    assign sclk   = s_q.sclk;
    assign cs_n   = s_q.cs_n;
    assign mosi   = ~s_q.cs_n & s_q.shreg[FRAME_W-1];
endmodule

// File: rtl/pcfg_seq_ctrl.sv
module pcfg_seq_ctrl
    import pcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic [1:0]         cmd_op,
    input  logic [VALUE_W-1:0] mode_cfg,
    input  logic               frame_done,
    output logic               load,
    output logic [FRAME_W-1:0] frame,
    output logic               busy,
    output logic               done
);
    typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_WAIT} sq_st_e;

    typedef struct packed {
        sq_st_e             st;
        pcfg_op_e           op;
        logic [VALUE_W-1:0] word;
        logic               step;
        logic               is_data;
        logic               busy;
        logic               done;
        logic               load;
        logic [FRAME_W-1:0] frame;
    } sq_state_t;

    localparam sq_state_t SQ_RST = '{st: SQ_IDLE, op: OP_SHUTDOWN, word: '0, step: 1'b0,
                                     is_data: 1'b0, busy: 1'b0, done: 1'b0,
                                     load: 1'b0, frame: '0};

    sq_state_t  s_d, s_q;
    reg_write_t cur_w;
    pcfg_op_e   req_op;

    always_comb begin
        req_op = pcfg_op_e'(cmd_op);
        cur_w  = step_write(s_q.op, s_q.step, s_q.word);
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.load = 1'b0;
        case (s_q.st)
            SQ_IDLE: begin
                if (cmd_start && (req_op != OP_RESERVED)) begin
                    s_d.op      = req_op;
                    s_d.word    = orient_word(mode_cfg);
                    s_d.step    = 1'b0;
                    s_d.is_data = 1'b0;
                    s_d.busy    = 1'b1;
                    s_d.st      = SQ_LOAD;
                end
            end
            SQ_LOAD: begin
                s_d.load  = 1'b1;
                s_d.frame = s_q.is_data ? {SEL_DATA, cur_w.value}
                                        : {SEL_INDEX, 8'h00, cur_w.regnum};
                s_d.st    = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (frame_done) begin
                    if (!s_q.is_data) begin
                        s_d.is_data = 1'b1;
                        s_d.st      = SQ_LOAD;
                    end else if (s_q.step == last_step(s_q.op)) begin
                        s_d.st   = SQ_IDLE;
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.step    = 1'b1;
                        s_d.is_data = 1'b0;
                        s_d.st      = SQ_LOAD;
                    end
                end
            end
            default: s_d = SQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SQ_RST;
        else        s_q <= s_d;
    end

    assign load  = s_q.load;
    assign frame = s_q.frame;
    assign busy  = s_q.busy;
    assign done  = s_q.done;
endmodule

// File: rtl/panel_cfg_seq.sv
module panel_cfg_seq
    import pcfg_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic [1:0]  cmd_op,
    input  logic [15:0] mode_cfg,
    output logic        busy,
    output logic        done,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n
);
    localparam int HALF_CYC  = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
    localparam int GAP_TICKS = 2;

    logic               tick;
    logic               tx_active;
    logic               tx_done;
    logic               tx_load;
    logic [FRAME_W-1:0] tx_frame;

    pcfg_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_op     (cmd_op),
        .mode_cfg   (mode_cfg),
        .frame_done (tx_done),
        .load       (tx_load),
        .frame      (tx_frame),
        .busy       (busy),
        .done       (done)
    );

    pcfg_tick_gen #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tx_active),
        .tick  (tick)
    );

    pcfg_frame_tx #(.FRAME_W(FRAME_W), .GAP_TICKS(GAP_TICKS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (tx_load),
        .frame      (tx_frame),
        .active     (tx_active),
        .frame_done (tx_done),
        .sclk       (spi_sclk),
        .mosi       (spi_mosi),
        .cs_n       (spi_cs_n)
    );
endmodule

// File: rtl/pcfg_chk.sv
module pcfg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic [1:0] cmd_op,
    input logic       busy,
    input logic       done,
    input logic       spi_sclk,
    input logic       spi_mosi,
    input logic       spi_cs_n
);
    // R7
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R7
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R9
    cs_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start && cmd_op != 2'b11) |=> busy);

    // R10
    reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start && cmd_op == 2'b11) |=> !busy);
endmodule

bind panel_cfg_seq pcfg_chk u_chk (.*);

// File: tb/panel_cfg_seq_tb.sv
module panel_cfg_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [15:0] mode_cfg = 16'h0000;
    logic        busy, done, spi_sclk, spi_mosi, spi_cs_n;

    int n_checks = 0;
    int n_fail   = 0;

    panel_cfg_seq #(.CLK_DIV(CLK_DIV)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // pin-level frame decoder
    logic [23:0] fr [0:7];
    int          frb [0:7];
    int          nfr = 0;
    logic [23:0] cur = '0;
    int          curbits = 0;
    int          cyc = 0;
    int          last_rise = 0;
    int          cs_high = 0;
    int          period_err = 0;
    int          gap_err = 0;
    logic        prev_sclk = 1'b0;
    logic        prev_cs = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!spi_cs_n && prev_cs) begin
                if (nfr > 0 && cs_high < CLK_DIV) gap_err++;
                curbits = 0;
                cur = '0;
            end
            if (!spi_cs_n && spi_sclk && !prev_sclk) begin
                if (curbits > 0 && (cyc - last_rise) != CLK_DIV) period_err++;
                last_rise = cyc;
                cur = {cur[22:0], spi_mosi};
                curbits++;
            end
            if (spi_cs_n && !prev_cs && nfr < 8) begin
                fr[nfr]  = cur;
                frb[nfr] = curbits;
                nfr++;
            end
            if (spi_cs_n) cs_high++;
            else          cs_high = 0;
        end
        prev_sclk = spi_sclk;
        prev_cs   = spi_cs_n;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [15:0] m);
        return (m & 16'h2B00) | 16'h00EF;
    endfunction

    task automatic run_seq(input logic [1:0] op, input logic [15:0] mode, input bit poke);
        logic [7:0]  er [0:1];
        logic [15:0] ev [0:1];
        int          nw;
        int          t;
        nfr = 0; period_err = 0; gap_err = 0;
        case (op)
            2'b00: begin nw = 2; er[0] = 8'h11; ev[0] = 16'h0000; er[1] = 8'h01; ev[1] = exp_word(mode); end
            2'b10: begin nw = 2; er[0] = 8'h01; ev[0] = exp_word(mode); er[1] = 8'h11; ev[1] = 16'h0000; end
            default: begin nw = 1; er[0] = 8'h11; ev[0] = 16'h0001; er[1] = 8'h00; ev[1] = 16'h0000; end
        endcase
        @(negedge clk);
        cmd_op = op; mode_cfg = mode; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; mode_cfg = ~mode;
        chk(busy == 1'b1, "R9 busy after start", {31'd0, busy}, 32'd1);
        if (poke) begin
            repeat (30) @(negedge clk);
            cmd_op = (op == 2'b01) ? 2'b00 : 2'b01;
            cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
        end
        t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        chk(t < 5000, "R9 done reached", t, 5000);
        chk(busy == 1'b0, "R9 busy low with done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", {31'd0, done}, 32'd0);
        repeat (3 * CLK_DIV) @(negedge clk);
        chk(nfr == 2 * nw, (op == 2'b00) ? "R3 frame count" : (op == 2'b10) ? "R4 frame count"
                           : poke ? "R10 frame count" : "R5 frame count", nfr, 2 * nw);
        for (int i = 0; i < nw && 2 * i + 1 < nfr; i++) begin
            chk(frb[2*i] == 24 && fr[2*i] == {8'h74, 8'h00, er[i]}, "R1 index frame",
                fr[2*i], {8'h74, 8'h00, er[i]});
            chk(frb[2*i+1] == 24 && fr[2*i+1] == {8'h76, ev[i]}, "R2 R6 data frame",
                fr[2*i+1], {8'h76, ev[i]});
        end
        chk(period_err == 0, "R7 sclk period", period_err, 0);
        chk(gap_err == 0, "R8 cs gap", gap_err, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy == 0 && done == 0 && spi_cs_n == 1 && spi_sclk == 0, "R11 reset outputs",
            {busy, done, spi_cs_n, spi_sclk}, 4'b0010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_seq(2'b00, 16'hFFFF, 1'b0);   // R3 R6 all mode bits set
        run_seq(2'b10, 16'h0000, 1'b0);   // R4 R6 nothing set
        run_seq(2'b01, 16'h1234, 1'b0);   // R5
        run_seq(2'b00, 16'hD4FF, 1'b0);   // R6 only ignored bits set
        run_seq(2'b10, 16'h2B00, 1'b1);   // R10 start while busy
        run_seq(2'b01, 16'h0000, 1'b1);   // R10 start while busy during shutdown

        // R10 reserved operation code
        nfr = 0;
        @(negedge clk);
        cmd_op = 2'b11; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        begin
            int hi = 0;
            for (int k = 0; k < 200; k++) begin
                if (busy) hi++;
                @(negedge clk);
            end
            chk(hi == 0, "R10 reserved op busy", hi, 0);
        end
        chk(nfr == 0, "R10 reserved op frames", nfr, 0);

        for (int r = 0; r < 10; r++) begin
            logic [1:0] op;
            op = 2'($urandom % 3);
            run_seq(op, 16'($urandom), 1'($urandom % 2));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule